// File: doc/BRIEF.md
# Semantic Region Address Router

This block stands between the load/store issue stage and a set of region-specific data translation buffers and cachelets. Every cycle up to four data virtual addresses arrive on numbered slots. Each address is compared with four software-loaded limit registers and labelled as a global-data, heap or stack reference. Each labelled reference is then steered to a port of its own region. The stack side has two ports. The global and heap sides have one port each.

When more references name a region in one cycle than that region has ports, the lower slot numbers win. The others are flagged as stalled, and the issue stage presents them again, unchanged, on a later cycle. An address outside every region is flagged as a region fault and is not routed. Each region port has a valid/ready pair. A routed reference is consumed only in a cycle where its port is both valid and ready. Otherwise its slot is stalled.

Top module: `region_router`

## Requirements
- R1: An address at or above the data-base limit and below the data-bound limit is classified global and is routed only to a global port.
- R2: An address at or above the data-bound limit and below the stack-limit register is classified heap and is routed only to the heap port.
- R3: An address at or above the stack-limit register and below the environment-base limit is classified stack and is routed only to a stack port. When misprogrammed limits make ranges overlap, the priority is global first, then heap, then stack.
- R4: A valid address that falls in no region raises `req_fault` for its slot. It appears on no port and does not raise `req_stall`.
- R5: A routed port carries the slot's address unchanged, and its tag equals the slot number, 0 to 3.
- R6: Within a region, requesting slots take ports in ascending slot order. The lowest requesting slot gets port 0 and the next gets port 1. The stack region has 2 ports and the global and heap regions have 1 port each.
- R7: A valid, classified slot that gets no port raises `req_stall`. When it is presented again on a later cycle with free ports, it is granted.
- R8: A granted slot is consumed (stall low) only when its port's ready is high. If that ready is low, the slot raises `req_stall` while its port still shows valid.
- R9: `cfg_sel` chooses the register written on `cfg_we`: 0 = data base, 1 = data bound, 2 = stack limit, 3 = environment base. A write affects classification from the next cycle onward, and never in the cycle of the strobe.
- R10: Reset clears all four limit registers. While they are zero, every valid address is reported as a region fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Limit register write strobe |
| cfg_sel | input | 2 | Limit register select |
| cfg_wdata | input | 32 | Limit register write value |
| req_valid | input | 4 | Per-slot reference valid |
| req_addr | input | 4x32 | Per-slot data virtual address |
| req_stall | output | 4 | Slot not consumed; re-present next cycle |
| req_fault | output | 4 | Slot address outside every region |
| stk_valid | output | 2 | Stack port valid |
| stk_addr | output | 2x32 | Stack port address |
| stk_tag | output | 2x2 | Stack port slot tag |
| stk_ready | input | 2 | Stack port ready |
| glb_valid | output | 1 | Global port valid |
| glb_addr | output | 1x32 | Global port address |
| glb_tag | output | 1x2 | Global port slot tag |
| glb_ready | input | 1 | Global port ready |
| heap_valid | output | 1 | Heap port valid |
| heap_addr | output | 1x32 | Heap port address |
| heap_tag | output | 1x2 | Heap port slot tag |
| heap_ready | input | 1 | Heap port ready |

## Verification
The bench builds the router with its default parameters: four slots, 32-bit addresses, two stack ports and one port each for global and heap. With these values, four stack references in one cycle leave two slots to stall. They also let three global or heap references pile onto a single port. The bench draws random addresses from a 16-bit window and writes random limit values. This makes empty, inverted and overlapping ranges common, so the region priority and the fault path are exercised next to normal traffic.

// File: rtl/region_router_pkg.sv
package region_router_pkg;

    typedef enum logic [1:0] {
        RGN_NONE   = 2'd0,
        RGN_GLOBAL = 2'd1,
        RGN_HEAP   = 2'd2,
        RGN_STACK  = 2'd3
    } region_e;

    localparam logic [1:0] SEL_DBASE  = 2'd0;
    localparam logic [1:0] SEL_DBOUND = 2'd1;
    localparam logic [1:0] SEL_SLIMIT = 2'd2;
    localparam logic [1:0] SEL_EBASE  = 2'd3;

endpackage

// File: rtl/region_classifier.sv
module region_classifier
    import region_router_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lim_dbase,
    input  logic [ADDR_W-1:0] lim_dbound,
    input  logic [ADDR_W-1:0] lim_slimit,
    input  logic [ADDR_W-1:0] lim_ebase,
    output region_e           region
);

    logic in_glb, in_heap, in_stk;

    always_comb begin
        in_glb  = (addr >= lim_dbase)  && (addr < lim_dbound);
        in_heap = (addr >= lim_dbound) && (addr < lim_slimit);
        in_stk  = (addr >= lim_slimit) && (addr < lim_ebase);
        if (in_glb) begin
            region = RGN_GLOBAL;
        end else if (in_heap) begin
            region = RGN_HEAP;
        end else if (in_stk) begin
            region = RGN_STACK;
        end else begin
            region = RGN_NONE;
        end
    end

endmodule

// File: rtl/port_allocator.sv
module port_allocator #(
    parameter int NSLOT  = 4,
    parameter int NPORT  = 2,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 2
) (
    input  logic [NSLOT-1:0]             slot_hit,
    input  logic [NSLOT-1:0][ADDR_W-1:0] slot_addr,
    input  logic [NPORT-1:0]             port_ready,
    output logic [NPORT-1:0]             port_valid,
    output logic [NPORT-1:0][ADDR_W-1:0] port_addr,
    output logic [NPORT-1:0][TAG_W-1:0]  port_tag,
    output logic [NSLOT-1:0]             slot_go
);

    int rank [NSLOT];

    always_comb begin
        int cnt;
        cnt = 0;
        for (int s = 0; s < NSLOT; s++) begin
            rank[s] = cnt;
            if (slot_hit[s]) begin
                cnt = cnt + 1;
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NPORT; p++) begin
            port_valid[p] = 1'b0;
            port_addr[p]  = '0;
            port_tag[p]   = '0;
            for (int s = 0; s < NSLOT; s++) begin
                if (slot_hit[s] && rank[s] == p) begin
                    port_valid[p] = 1'b1;
                    port_addr[p]  = slot_addr[s];
                    port_tag[p]   = TAG_W'(s);
                end
            end
        end
    end

    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            slot_go[s] = 1'b0;
            for (int p = 0; p < NPORT; p++) begin
                if (slot_hit[s] && rank[s] == p && port_ready[p]) begin
                    slot_go[s] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/region_router.sv
module region_router
    import region_router_pkg::*;
#(
    parameter int NSLOT      = 4,
    parameter int ADDR_W     = 32,
    parameter int STK_PORTS  = 2,
    parameter int GLB_PORTS  = 1,
    parameter int HEAP_PORTS = 1,
    localparam int TAG_W     = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_we,
    input  logic [1:0]                           cfg_sel,
    input  logic [ADDR_W-1:0]                    cfg_wdata,
    input  logic [NSLOT-1:0]                     req_valid,
    input  logic [NSLOT-1:0][ADDR_W-1:0]         req_addr,
    output logic [NSLOT-1:0]                     req_stall,
    output logic [NSLOT-1:0]                     req_fault,
    output logic [STK_PORTS-1:0]                 stk_valid,
    output logic [STK_PORTS-1:0][ADDR_W-1:0]     stk_addr,
    output logic [STK_PORTS-1:0][TAG_W-1:0]      stk_tag,
    input  logic [STK_PORTS-1:0]                 stk_ready,
    output logic [GLB_PORTS-1:0]                 glb_valid,
    output logic [GLB_PORTS-1:0][ADDR_W-1:0]     glb_addr,
    output logic [GLB_PORTS-1:0][TAG_W-1:0]      glb_tag,
    input  logic [GLB_PORTS-1:0]                 glb_ready,
    output logic [HEAP_PORTS-1:0]                heap_valid,
    output logic [HEAP_PORTS-1:0][ADDR_W-1:0]    heap_addr,
    output logic [HEAP_PORTS-1:0][TAG_W-1:0]     heap_tag,
    input  logic [HEAP_PORTS-1:0]                heap_ready
);

    typedef struct packed {
        logic [ADDR_W-1:0] dbase;
        logic [ADDR_W-1:0] dbound;
        logic [ADDR_W-1:0] slimit;
        logic [ADDR_W-1:0] ebase;
    } limits_t;

    limits_t lim_d, lim_q;

    always_comb begin
        lim_d = lim_q;
        if (cfg_we) begin
            case (cfg_sel)
                SEL_DBASE:  lim_d.dbase  = cfg_wdata;
                SEL_DBOUND: lim_d.dbound = cfg_wdata;
                SEL_SLIMIT: lim_d.slimit = cfg_wdata;
                default:    lim_d.ebase  = cfg_wdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= '0;
        end else begin
            lim_q <= lim_d;
        end
    end

    region_e          slot_region [NSLOT];
    logic [NSLOT-1:0] hit_stk, hit_glb, hit_heap;
    logic [NSLOT-1:0] go_stk, go_glb, go_heap;

    for (genvar s = 0; s < NSLOT; s++) begin : g_cls
        region_classifier #(.ADDR_W(ADDR_W)) u_cls (
            .addr       (req_addr[s]),
            .lim_dbase  (lim_q.dbase),
            .lim_dbound (lim_q.dbound),
            .lim_slimit (lim_q.slimit),
            .lim_ebase  (lim_q.ebase),
            .region     (slot_region[s])
        );
    end

    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            hit_stk[s]  = req_valid[s] && (slot_region[s] == RGN_STACK);
            hit_glb[s]  = req_valid[s] && (slot_region[s] == RGN_GLOBAL);
            hit_heap[s] = req_valid[s] && (slot_region[s] == RGN_HEAP);
        end
    end

    port_allocator #(
        .NSLOT(NSLOT), .NPORT(STK_PORTS), .ADDR_W(ADDR_W), .TAG_W(TAG_W)
    ) u_alloc_stk (
        .slot_hit   (hit_stk),
        .slot_addr  (req_addr),
        .port_ready (stk_ready),
        .port_valid (stk_valid),
        .port_addr  (stk_addr),
        .port_tag   (stk_tag),
        .slot_go    (go_stk)
    );

    port_allocator #(
        .NSLOT(NSLOT), .NPORT(GLB_PORTS), .ADDR_W(ADDR_W), .TAG_W(TAG_W)
    ) u_alloc_glb (
        .slot_hit   (hit_glb),
        .slot_addr  (req_addr),
        .port_ready (glb_ready),
        .port_valid (glb_valid),
        .port_addr  (glb_addr),
        .port_tag   (glb_tag),
        .slot_go    (go_glb)
    );

    port_allocator #(
        .NSLOT(NSLOT), .NPORT(HEAP_PORTS), .ADDR_W(ADDR_W), .TAG_W(TAG_W)
    ) u_alloc_heap (
        .slot_hit   (hit_heap),
        .slot_addr  (req_addr),
        .port_ready (heap_ready),
        .port_valid (heap_valid),
        .port_addr  (heap_addr),
        .port_tag   (heap_tag),
        .slot_go    (go_heap)
    );

    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            req_fault[s] = req_valid[s] && (slot_region[s] == RGN_NONE);
            req_stall[s] = req_valid[s] && (slot_region[s] != RGN_NONE)
                           && !(go_stk[s] || go_glb[s] || go_heap[s]);
        end
    end

endmodule

// File: rtl/region_router_chk.sv
module region_router_chk #(
    parameter int NSLOT      = 4,
    parameter int ADDR_W     = 32,
    parameter int STK_PORTS  = 2,
    parameter int GLB_PORTS  = 1,
    parameter int HEAP_PORTS = 1,
    parameter int TAG_W      = 2
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NSLOT-1:0]                  req_valid,
    input logic [NSLOT-1:0][ADDR_W-1:0]      req_addr,
    input logic [NSLOT-1:0]                  req_stall,
    input logic [NSLOT-1:0]                  req_fault,
    input logic [STK_PORTS-1:0]              stk_valid,
    input logic [STK_PORTS-1:0][ADDR_W-1:0]  stk_addr,
    input logic [STK_PORTS-1:0][TAG_W-1:0]   stk_tag,
    input logic [STK_PORTS-1:0]              stk_ready,
    input logic [GLB_PORTS-1:0]              glb_valid,
    input logic [GLB_PORTS-1:0][TAG_W-1:0]   glb_tag,
    input logic [GLB_PORTS-1:0]              glb_ready
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // R4: a faulted slot is never also stalled, and needs a valid request
        a_r4_fault_not_stalled: assert property (@(posedge clk) disable iff (!rst_n)
            req_fault[s] |-> (req_valid[s] && !req_stall[s]));
    end

    for (genvar p = 0; p < STK_PORTS; p++) begin : g_stk
        // R5: a stack port echoes the address of a valid slot named by its tag
        a_r5_stk_port_source: assert property (@(posedge clk) disable iff (!rst_n)
            stk_valid[p] |-> (req_valid[stk_tag[p]] && req_addr[stk_tag[p]] == stk_addr[p]));
        // R8: a port held back by ready keeps its slot stalled
        a_r8_stk_wait_stalls: assert property (@(posedge clk) disable iff (!rst_n)
            (stk_valid[p] && !stk_ready[p]) |-> req_stall[stk_tag[p]]);
    end

    if (STK_PORTS >= 2) begin : g_order
        // R6: port 1 used only after port 0, and by a higher slot
        a_r6_stk_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
            stk_valid[1] |-> (stk_valid[0] && stk_tag[0] < stk_tag[1]));
    end

    // R8: a global reference accepted by ready is not stalled
    a_r8_glb_take: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_valid[0] && glb_ready[0]) |-> !req_stall[glb_tag[0]]);

    // R10: right after reset the cleared limits fault every request
    a_r10_reset_faults: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && req_valid[0]) |-> req_fault[0]);

endmodule

bind region_router region_router_chk #(
    .NSLOT(NSLOT), .ADDR_W(ADDR_W), .STK_PORTS(STK_PORTS),
    .GLB_PORTS(GLB_PORTS), .HEAP_PORTS(HEAP_PORTS), .TAG_W(TAG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_stall(req_stall), .req_fault(req_fault),
    .stk_valid(stk_valid), .stk_addr(stk_addr), .stk_tag(stk_tag), .stk_ready(stk_ready),
    .glb_valid(glb_valid), .glb_tag(glb_tag), .glb_ready(glb_ready)
);

// File: tb/tb_region_router.sv
`timescale 1ns/1ps
module tb_region_router;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cfg_we = 1'b0;
    logic [1:0]           cfg_sel = '0;
    logic [31:0]          cfg_wdata = '0;
    logic [3:0]           req_valid = '0;
    logic [3:0][31:0]     req_addr = '0;
    logic [3:0]           req_stall, req_fault;
    logic [1:0]           stk_valid;
    logic [1:0][31:0]     stk_addr;
    logic [1:0][1:0]      stk_tag;
    logic [1:0]           stk_ready = '1;
    logic [0:0]           glb_valid, heap_valid;
    logic [0:0][31:0]     glb_addr, heap_addr;
    logic [0:0][1:0]      glb_tag, heap_tag;
    logic [0:0]           glb_ready = '1, heap_ready = '1;

    always #5 clk = ~clk;

    region_router dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_stall(req_stall), .req_fault(req_fault),
        .stk_valid(stk_valid), .stk_addr(stk_addr), .stk_tag(stk_tag), .stk_ready(stk_ready),
        .glb_valid(glb_valid), .glb_addr(glb_addr), .glb_tag(glb_tag), .glb_ready(glb_ready),
        .heap_valid(heap_valid), .heap_addr(heap_addr), .heap_tag(heap_tag), .heap_ready(heap_ready)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // staged stimulus, applied at the falling edge
    logic        s_rst_n = 1'b0, s_we = 1'b0;
    logic [1:0]  s_sel = '0;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_valid = '0;
    logic [31:0] s_addr [4];
    logic [1:0]  s_stk_rdy = '1;
    logic        s_glb_rdy = 1'b1, s_heap_rdy = 1'b1;

    // reference model state: the four limits
    logic [31:0] m_lim [4];

    function automatic int classify(logic [31:0] a);
        if (a >= m_lim[0] && a < m_lim[1]) return 1;
        if (a >= m_lim[1] && a < m_lim[2]) return 2;
        if (a >= m_lim[2] && a < m_lim[3]) return 3;
        return 0;
    endfunction

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
        end
    endtask

    task automatic tick(string rq);
        int          np [4];
        int          cnt [4];
        logic [3:0]  ef, es;
        logic        ev [4][2];
        logic [31:0] ea [4][2];
        logic [1:0]  et [4][2];
        logic        rdy [4][2];
        logic        dv [4][2];
        logic [31:0] da [4][2];
        logic [1:0]  dt [4][2];
        np = '{0, 1, 1, 2};
        @(negedge clk);
        rst_n = s_rst_n;
        cfg_we = s_we; cfg_sel = s_sel; cfg_wdata = s_wdata;
        req_valid = s_valid;
        for (int s = 0; s < 4; s++) req_addr[s] = s_addr[s];
        stk_ready = s_stk_rdy; glb_ready[0] = s_glb_rdy; heap_ready[0] = s_heap_rdy;
        if (!s_rst_n) for (int i = 0; i < 4; i++) m_lim[i] = '0;
        #2;
        for (int r = 0; r < 4; r++) begin
            cnt[r] = 0;
            for (int k = 0; k < 2; k++) begin
                ev[r][k] = 1'b0; ea[r][k] = '0; et[r][k] = '0; rdy[r][k] = 1'b0;
                dv[r][k] = 1'b0; da[r][k] = '0; dt[r][k] = '0;
            end
        end
        rdy[1][0] = s_glb_rdy; rdy[2][0] = s_heap_rdy;
        rdy[3][0] = s_stk_rdy[0]; rdy[3][1] = s_stk_rdy[1];
        ef = '0; es = '0;
        for (int s = 0; s < 4; s++) begin
            if (s_valid[s]) begin
                int r;
                r = classify(s_addr[s]);
                if (r == 0) begin
                    ef[s] = 1'b1;
                end else if (cnt[r] < np[r]) begin
                    ev[r][cnt[r]] = 1'b1;
                    ea[r][cnt[r]] = s_addr[s];
                    et[r][cnt[r]] = 2'(s);
                    es[s] = !rdy[r][cnt[r]];
                    cnt[r]++;
                end else begin
                    es[s] = 1'b1;
                    cnt[r]++;
                end
            end
        end
        dv[1][0] = glb_valid[0];  da[1][0] = glb_addr[0];  dt[1][0] = glb_tag[0];
        dv[2][0] = heap_valid[0]; da[2][0] = heap_addr[0]; dt[2][0] = heap_tag[0];
        for (int k = 0; k < 2; k++) begin
            dv[3][k] = stk_valid[k]; da[3][k] = stk_addr[k]; dt[3][k] = stk_tag[k];
        end
        chk({rq, "/R4"}, "fault", {28'd0, req_fault}, {28'd0, ef});
        chk({rq, "/R7"}, "stall", {28'd0, req_stall}, {28'd0, es});
        for (int r = 1; r < 4; r++) begin
            for (int k = 0; k < np[r]; k++) begin
                chk({rq, "/R6"}, $sformatf("valid rgn%0d port%0d", r, k),
                    {31'd0, dv[r][k]}, {31'd0, ev[r][k]});
                if (ev[r][k]) begin
                    chk({rq, "/R5"}, $sformatf("addr rgn%0d port%0d", r, k), da[r][k], ea[r][k]);
                    chk({rq, "/R5"}, $sformatf("tag rgn%0d port%0d", r, k),
                        {30'd0, dt[r][k]}, {30'd0, et[r][k]});
                end
            end
        end
        @(posedge clk);
        #1;
        if (s_rst_n && s_we) m_lim[s_sel] = s_wdata;
    endtask

    task automatic set_req(logic [3:0] v, logic [31:0] a0, logic [31:0] a1,
                           logic [31:0] a2, logic [31:0] a3);
        s_valid = v;
        s_addr[0] = a0; s_addr[1] = a1; s_addr[2] = a2; s_addr[3] = a3;
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] val);
        s_we = 1'b1; s_sel = sel; s_wdata = val;
    endtask

    task automatic idle_cfg();
        s_we = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin m_lim[i] = '0; s_addr[i] = '0; end
        // R10: requests during and just after reset all fault
        set_req(4'hF, 32'h1500, 32'h2500, 32'h8800, 32'h9000);
        repeat (3) tick("R10");
        s_rst_n = 1'b1;
        tick("R10");
        // R9: a write does not act in its own cycle
        wr(2'd0, 32'h1000);
        set_req(4'h1, 32'h1500, 0, 0, 0);
        tick("R9");
        wr(2'd1, 32'h3000); tick("R9");
        wr(2'd2, 32'h8000); tick("R9");
        wr(2'd3, 32'hA000); tick("R9");
        idle_cfg();
        // R1: four global references share one port
        set_req(4'hF, 32'h1000, 32'h1004, 32'h2FFC, 32'h2000); tick("R1");
        // R2: heap references, boundary values
        set_req(4'hA, 0, 32'h3000, 0, 32'h7FFC); tick("R2");
        // R3: four stack references, two ports
        set_req(4'hF, 32'h8000, 32'h9000, 32'h9FFC, 32'h8800); tick("R3");
        // R7: stalled slots presented again win ports
        set_req(4'hC, 0, 0, 32'h9FFC, 32'h8800); tick("R7");
        // R6: mixed regions, one reference each plus extra stack
        set_req(4'hF, 32'h9000, 32'h1800, 32'h4000, 32'h8100); tick("R6");
        // R8: ready held low on stack port 0 and global port
        s_stk_rdy = 2'b10; s_glb_rdy = 1'b0;
        set_req(4'hF, 32'h9000, 32'h1800, 32'h8004, 32'h4000); tick("R8");
        s_stk_rdy = 2'b11; s_glb_rdy = 1'b1;
        // R4: addresses below data base and above environment base
        set_req(4'hF, 32'h0FFC, 32'hA000, 32'h8000, 32'hFFFF0000); tick("R4");
        // R3: overlap, stack limit below data bound: global wins
        wr(2'd2, 32'h2000); set_req(4'h0, 0, 0, 0, 0); tick("R3");
        idle_cfg();
        set_req(4'h7, 32'h2800, 32'h2000, 32'h1FFC, 0); tick("R3");
        wr(2'd2, 32'h8000); tick("R9");
        idle_cfg();
        // random traffic with occasional limit writes and one reset
        for (int n = 0; n < 600; n++) begin
            s_valid = 4'($urandom());
            for (int s = 0; s < 4; s++) s_addr[s] = $urandom() & 32'h0000FFFF;
            s_stk_rdy = 2'($urandom()); s_glb_rdy = 1'($urandom()); s_heap_rdy = 1'($urandom());
            if (($urandom() % 8) == 0) wr(2'($urandom()), $urandom() & 32'h0000FFFF);
            else idle_cfg();
            s_rst_n = (n != 300);
            tick((n == 301) ? "R10" : "R6");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule